// File: doc/BRIEF.md
# Packet-Framed Byte-Bus SRAM Bridge

This bridge lets a host that has only a clock, a start strobe and one 8-bit bidirectional data lane read and write an asynchronous byte-wide SRAM in bursts. The host opens each transaction by raising the strobe on the cycle it presents a command byte. The command byte gives the direction and a burst length. Three address bytes follow, and then the data bytes. The bridge loads an internal address counter from the header. It then generates the SRAM address, chip-enable, output-enable and write-enable for every data byte and moves to the next address after each byte.

The two directions have different timing. Writes accept one byte per clock, starting on the clock right after the last address byte. Reads insert one turnaround clock so the host can release the lane. Each read byte then takes two clocks: in the first the SRAM access completes and is latched, and in the second the bridge drives the host lane. Write-enable is pulsed only during the low half of a clock, so the SRAM address always moves while write-enable is inactive.

A length of zero gives an open-ended burst. Any strobe, in any state, drops the current transfer and starts a new header.

Top module: `pkt_sram_bridge`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after that edge, the bridge is idle: `host_dout_en` is 0 and `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1.
- R2: A byte sampled with `host_strobe` high is a command. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 hold the burst length in data bytes.
- R3: The three bytes after the command form the 24-bit start address, most significant byte first. The first data byte uses exactly that address on `sram_addr`.
- R4: In a write, data bytes begin on the clock right after the third address byte, one per clock. Each byte appears on `sram_wdata` with `sram_ce_n` low and `sram_we_n` low during the low half of the following clock.
- R5: `sram_we_n` is 1 whenever the clock is high. Every change of `sram_addr`, which happens at a rising edge, therefore occurs with write-enable inactive.
- R6: In a read, the byte after the address is a turnaround and is ignored. Each data byte then takes two clocks, both with `sram_ce_n` and `sram_oe_n` low. In the second clock `host_dout_en` is 1 and `host_dout` carries the SRAM byte at the current address.
- R7: The address rises by one after every data byte in both directions, and wraps from 0xFFFFFF to 0x000000.
- R8: A length of 0 keeps the burst running for as many bytes as the host supplies, until the next strobe or reset.
- R9: A non-zero length N ends the burst after N data bytes. Bytes that arrive afterwards without a strobe cause no SRAM access, and `sram_ce_n` stays 1.
- R10: A strobe in any state, including mid-header and mid-read-byte, abandons the current transfer and takes the byte as a new command.
- R11: `host_dout_en` is 0 in every clock except the second clock of a read data byte, including during the header and the turnaround.
- R12: A reset asserted in the middle of a burst ends it. Later bytes without a strobe cause no SRAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied clock; the bridge samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | High during the command byte of a new transaction |
| host_din | input | 8 | Byte from the host lane |
| host_dout | output | 8 | Read byte toward the host lane |
| host_dout_en | output | 1 | Tri-state enable for the host lane driver |
| sram_addr | output | 24 | SRAM address |
| sram_wdata | output | 8 | Write data to the SRAM |
| sram_rdata | input | 8 | Read data from the SRAM |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low, low-half-clock pulse |

## Verification
Two events can land in the same clock. The first is the write-enable pulse for the last staged write byte, which coincides with a new strobe arriving on the next byte. The second is the second half of a read byte, which can coincide with a strobe that must cut the host drive off on the next clock. Both are provoked by placing the strobe immediately after a write burst and in the middle of a two-clock read byte. A behavioural model predicts the SRAM pins and the host lane for every clock, and the results are checked there. The final memory contents are also checked, so a lost or duplicated write is caught.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = BYTE_W - 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_TURN,
        S_WDATA,
        S_RD_A,
        S_RD_B
    } brg_state_e;

    typedef struct packed {
        logic             is_write;
        logic [LEN_W-1:0] len;
    } brg_cmd_t;

    function automatic brg_cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        brg_cmd_t c;
        c.is_write = b[BYTE_W-1];
        c.len      = b[LEN_W-1:0];
        return c;
    endfunction

    // True when the byte being completed is the last one of a bounded burst
    function automatic logic burst_last(input logic [LEN_W-1:0] len,
                                        input logic [LEN_W-1:0] cnt);
        return (len != '0) && (LEN_W'(cnt + LEN_W'(1)) == len);
    endfunction

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] din,
    output logic [AW-1:0]     cur_addr,
    output logic              wr_take,
    output logic              rd_first,
    output logic              rd_second
);
    localparam int NB    = AW / BYTE_W;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    brg_state_e       st;
    brg_cmd_t         cmd;
    logic [AW-1:0]    hdr_addr;
    logic [AW-1:0]    addr_full;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] cnt;
    logic             adv;

    assign addr_full = {hdr_addr[AW-BYTE_W-1:0], din};
    assign wr_take   = (st == S_WDATA) && !strobe;
    assign rd_first  = (st == S_RD_A);
    assign rd_second = (st == S_RD_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cmd      <= '0;
            hdr_addr <= '0;
            idx      <= '0;
            cnt      <= '0;
            adv      <= 1'b0;
            cur_addr <= '0;
        end else if (strobe) begin
            st  <= S_ADDR;
            cmd <= decode_cmd(din);
            idx <= '0;
            cnt <= '0;
            adv <= 1'b0;
        end else begin
            case (st)
                S_ADDR: begin
                    hdr_addr <= addr_full;
                    idx      <= idx + IDX_W'(1);
                    if (idx == IDX_W'(NB - 1)) begin
                        cur_addr <= addr_full;
                        st       <= cmd.is_write ? S_WDATA : S_TURN;
                    end
                end
                S_TURN: st <= S_RD_A;
                S_WDATA: begin
                    cur_addr <= cur_addr + AW'(adv);
                    adv      <= 1'b1;
                    cnt      <= cnt + LEN_W'(1);
                    if (burst_last(cmd.len, cnt)) st <= S_IDLE;
                end
                S_RD_A: st <= S_RD_B;
                S_RD_B: begin
                    cnt <= cnt + LEN_W'(1);
                    if (burst_last(cmd.len, cnt)) begin
                        st <= S_IDLE;
                    end else begin
                        st       <= S_RD_A;
                        cur_addr <= cur_addr + AW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R6
    rd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_RD_B) |-> ($past(st) == S_RD_A));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (st == S_ADDR && idx == '0));

    // R8
    open_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_WDATA && cmd.len == '0 && !strobe) |=> (st == S_WDATA));

endmodule

// File: rtl/bridge_sram_if.sv
module bridge_sram_if
    import bridge_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_take,
    input  logic              rd_first,
    input  logic              rd_second,
    input  logic [BYTE_W-1:0] din,
    input  logic [AW-1:0]     cur_addr,
    output logic [AW-1:0]     sram_addr,
    output logic [BYTE_W-1:0] sram_wdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    logic              wr_vld;
    logic [BYTE_W-1:0] wr_dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_vld <= 1'b0;
            wr_dat <= '0;
        end else begin
            wr_vld <= wr_take;
            if (wr_take) wr_dat <= din;
        end
    end

    assign sram_addr  = cur_addr;
    assign sram_wdata = wr_dat;
    assign sram_ce_n  = ~(wr_vld | rd_first | rd_second);
    assign sram_oe_n  = ~(rd_first | rd_second);
    // Pulse only in the low half: released at the rising edge, ahead of the address register
    assign sram_we_n  = ~(wr_vld & ~clk);

    // R7
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && $past(wr_vld)) |-> (sram_addr == AW'($past(sram_addr) + AW'(1))));

endmodule

// File: rtl/bridge_host_if.sv
module bridge_host_if
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_first,
    input  logic              rd_second,
    input  logic [BYTE_W-1:0] sram_rdata,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_dout_en
);
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst)           rd_q <= '0;
        else if (rd_first) rd_q <= sram_rdata;
    end

    assign host_dout_en = rd_second;
    assign host_dout    = rd_second ? rd_q : '0;

    // R11
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        host_dout_en |-> $past(rd_first));

endmodule

// File: rtl/pkt_sram_bridge.sv
module pkt_sram_bridge
    import bridge_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_strobe,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_dout_en,
    output logic [AW-1:0]     sram_addr,
    output logic [BYTE_W-1:0] sram_wdata,
    input  logic [BYTE_W-1:0] sram_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    logic [AW-1:0] cur_addr;
    logic          wr_take;
    logic          rd_first;
    logic          rd_second;

    bridge_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .strobe    (host_strobe),
        .din       (host_din),
        .cur_addr  (cur_addr),
        .wr_take   (wr_take),
        .rd_first  (rd_first),
        .rd_second (rd_second)
    );

    bridge_sram_if #(.AW(AW)) u_sram (
        .clk        (clk),
        .rst        (rst),
        .wr_take    (wr_take),
        .rd_first   (rd_first),
        .rd_second  (rd_second),
        .din        (host_din),
        .cur_addr   (cur_addr),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_ce_n  (sram_ce_n),
        .sram_oe_n  (sram_oe_n),
        .sram_we_n  (sram_we_n)
    );

    bridge_host_if u_host (
        .clk          (clk),
        .rst          (rst),
        .rd_first     (rd_first),
        .rd_second    (rd_second),
        .sram_rdata   (sram_rdata),
        .host_dout    (host_dout),
        .host_dout_en (host_dout_en)
    );

endmodule

// File: tb/sim_pkt_sram_bridge.sv
module sim_pkt_sram_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int AMASK      = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strb = 1'b0;
    logic [7:0]  hdin = 8'h00;
    logic [7:0]  host_dout;
    logic        host_dout_en;
    logic [23:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    byte unsigned sram    [int];
    byte unsigned ref_mem [int];

    int checks = 0;
    int errors = 0;
    string ctx = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_sram_bridge u0 (
        .clk(clk), .rst(rst), .host_strobe(strb), .host_din(hdin),
        .host_dout(host_dout), .host_dout_en(host_dout_en),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    // Behavioural asynchronous SRAM
    always @(sram_we_n or sram_ce_n or sram_addr or sram_wdata)
        if (!sram_we_n && !sram_ce_n) sram[int'(sram_addr)] = sram_wdata;
    always @(sram_addr or sram_oe_n or sram_ce_n or sram_we_n)
        sram_rdata = (!sram_oe_n && !sram_ce_n && sram.exists(int'(sram_addr)))
                     ? sram[int'(sram_addr)] : 8'h00;

    // Reference model state
    int ph = 0, hn = 0, mlen = 0, maddr = 0, mdone = 0, rhalf = 0;
    bit mwr = 0;
    bit e_hoe, e_ce, e_roe, e_we;
    int e_dout, e_addr, e_wdat;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s [%s] actual %0h expected %0h", req, what, ctx, act, exp);
        end
    endtask

    function automatic int memref(input int a);
        return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
    endfunction

    task automatic mdl_step(input bit r, input bit s, input logic [7:0] b);
        e_hoe = 0; e_ce = 0; e_roe = 0; e_we = 0;
        if (r) begin
            ph = 0;
        end else if (s) begin
            ph = 1; hn = 0; mwr = b[7]; mlen = int'(b[6:0]); maddr = 0; mdone = 0;
        end else if (ph == 1) begin
            maddr = ((maddr << 8) | int'(b)) & AMASK;
            hn++;
            if (hn == 3) ph = mwr ? 2 : 3;
        end else if (ph == 3) begin
            ph = 4; rhalf = 0;
            e_ce = 1; e_roe = 1; e_addr = (maddr + mdone) & AMASK;
        end else if (ph == 2) begin
            e_addr = (maddr + mdone) & AMASK;
            e_we = 1; e_ce = 1; e_wdat = int'(b);
            ref_mem[e_addr] = b;
            mdone++;
            if (mlen != 0 && mdone == mlen) ph = 0;
        end else if (ph == 4) begin
            if (rhalf == 0) begin
                rhalf = 1;
                e_ce = 1; e_roe = 1; e_hoe = 1;
                e_addr = (maddr + mdone) & AMASK;
                e_dout = memref(e_addr);
            end else begin
                mdone++;
                if (mlen != 0 && mdone == mlen) ph = 0;
                else begin
                    rhalf = 0; e_ce = 1; e_roe = 1;
                    e_addr = (maddr + mdone) & AMASK;
                end
            end
        end
    endtask

    task automatic cyc(input bit r, input bit s, input logic [7:0] b);
        rst = r; strb = s; hdin = b;
        @(posedge clk); #1;
        mdl_step(r, s, b);
        chk("R5", "we_n while clock high", 32'(sram_we_n), 32'd1);
        @(negedge clk); #1;
        if (r) begin
            chk("R1", "host_dout_en in reset", 32'(host_dout_en), 32'd0);
            chk("R1", "ce_n in reset", 32'(sram_ce_n), 32'd1);
            chk("R1", "oe_n in reset", 32'(sram_oe_n), 32'd1);
            chk("R1", "we_n in reset", 32'(sram_we_n), 32'd1);
        end else begin
            chk("R11", "host_dout_en", 32'(host_dout_en), 32'(e_hoe));
            if (e_hoe) chk("R6", "host_dout", 32'(host_dout), 32'(e_dout));
            chk("R9", "ce_n", 32'(sram_ce_n), 32'(!e_ce));
            chk("R6", "oe_n", 32'(sram_oe_n), 32'(!e_roe));
            chk("R4", "we_n low half", 32'(sram_we_n), 32'(!e_we));
            if (e_ce) chk("R7", "sram_addr", 32'(sram_addr), 32'(e_addr));
            if (e_we) chk("R4", "sram_wdata", 32'(sram_wdata), 32'(e_wdat));
        end
    endtask

    // R2 R3: command then three address bytes, most significant first
    task automatic send_hdr(input bit wr, input int len, input int addr);
        cyc(0, 1, {wr, 7'(len)});
        cyc(0, 0, 8'(addr >> 16));
        cyc(0, 0, 8'(addr >> 8));
        cyc(0, 0, 8'(addr));
    endtask

    task automatic write_pkt(input int addr, input int len, input int n, input int seed);
        send_hdr(1'b1, len, addr);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'(seed + 7 * i));
    endtask

    task automatic read_pkt(input int addr, input int len, input int ncyc);
        send_hdr(1'b0, len, addr);
        cyc(0, 0, 8'hC3);
        for (int i = 0; i < ncyc; i++) cyc(0, 0, 8'(8'h90 + i));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state
        ctx = "reset";
        repeat (3) cyc(1, 0, 8'h00);
        cyc(0, 0, 8'h00);

        // R2 R3 R4 R7: bounded write then readback (R6)
        ctx = "write4";
        write_pkt(32'h123456, 4, 4, 8'hA0);
        cyc(0, 0, 8'h00);
        ctx = "read4";
        read_pkt(32'h123456, 4, 8);
        cyc(0, 0, 8'h00);

        // R8: open write of 6 bytes, ended by strobe (R10)
        ctx = "open write";
        write_pkt(32'h000100, 0, 6, 8'h31);
        // R8 R10: open read cut by strobe in the second clock of the fifth byte
        ctx = "open read abort";
        read_pkt(32'h000100, 0, 9);
        // R7 wrap + strobe in the cycle of the last staged write pulse
        ctx = "wrap write";
        write_pkt(32'hFFFFFF, 2, 2, 8'h5C);
        ctx = "wrap read";
        read_pkt(32'hFFFFFF, 2, 4);

        // R10: abort mid-header, then a full write
        ctx = "header abort";
        cyc(0, 1, 8'h83);
        cyc(0, 0, 8'h00);
        write_pkt(32'h000200, 3, 3, 8'h71);

        // R9: extra bytes after the length is used up
        ctx = "length stop";
        write_pkt(32'h000300, 2, 5, 8'h0E);
        cyc(0, 0, 8'h00);

        // R12: reset mid-burst, then stray bytes
        ctx = "reset mid burst";
        write_pkt(32'h000400, 0, 2, 8'hE1);
        cyc(1, 0, 8'h00);
        for (int i = 0; i < 3; i++) cyc(0, 0, 8'(8'h40 + i));
        ctx = "readback";
        read_pkt(32'h000400, 3, 6);
        read_pkt(32'h000300, 3, 6);
        read_pkt(32'h000200, 3, 6);
        cyc(0, 0, 8'h00);

        // R4 R9 R12: final SRAM contents against the expected image
        ctx = "memory image";
        foreach (ref_mem[a]) chk("R4", "stored byte", sram.exists(a) ? 32'(sram[a]) : 32'hFFFF_FFFF, 32'(ref_mem[a]));
        foreach (sram[a]) chk("R9", "no stray write", 32'(ref_mem.exists(a)), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule